// File: doc/BRIEF.md
# Wake-Up Interval Timer with Strobed Settings Transfer

This block counts down a 16-bit interval in an always-on domain and raises a wake-up request each time the interval expires. The processor does not write the always-on state directly. It writes a control byte and two interval bytes into a processor-side register bank. It then takes a strobe bit in the control byte from 0 to 1, and that strobe moves the settings across.

After a fixed number of slow-clock ticks the transfer lands. It updates the run state, the reload value, two retained user bits and the wake-up flag, and it can also load the counter. A completion flag then reports that the bank can take new settings. Both the completion flag and the always-on wake-up flag can drive one interrupt request.

Reads of the wake-up flag and of the two user bits return the always-on copies and not the values last written. For that reason, software clears the wake-up flag by writing it to 0 and then strobing, not by a read-modify-write.

Top module: `wake_interval_timer`

## Requirements
- R1: Address 94H reads {RUN(7), WUP(6), TEST(5), CPL(4), Z1(3), Z0(2), LOAD(1), SET(0)}. Address 95H reads interval bits 7..0 and address 96H reads bits 15..8. Every other address reads 00H.
- R2: After reset every readable bit is 0, the counter is stopped, and the reload value is 0000H.
- R3: A 0-to-1 change of the written SET bit starts a transfer. The transfer applies the RUN, WUP, Z and interval values captured at its start on the clock edge of the second slow tick after it starts. CPL (xfer_done) rises on that same edge and stays 0 while no slow tick arrives.
- R4: A SET rising edge that arrives while a transfer is in flight is ignored. It does not restart the transfer and does not replace the captured values.
- R5: Only a software write to 94H with bit 4 = 0 clears CPL. Writing bit 4 = 1 leaves it unchanged.
- R6: The counter is loaded from the new reload value only when the captured LOAD bit is 1. A transfer with LOAD = 0 leaves the count unchanged.
- R7: While the applied RUN is 1, each selected tick decrements the counter. The tick that would take it to zero (or that finds it at zero) instead sets the wake-up flag and reloads the counter. While RUN is 0 the count holds.
- R8: Bit 6 reads the always-on wake-up flag. Writing bit 6 changes only the bank copy. A later transfer forces the flag to that copy, so it clears with 0 or sets with 1.
- R9: TEST = 1 makes the counter step on test_tick instead of norm_tick.
- R10: wake_irq = irq_en AND (CPL OR (wake-up flag AND stby)).
- R11: Bits 3..2 read the always-on user bits. These bits change only when a transfer lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Primary reset, active low |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_we | input | 1 | Write strobe |
| sfr_rdata | output | 8 | Read data for sfr_addr |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| norm_tick | input | 1 | Normal counter tick enable |
| test_tick | input | 1 | Test-mode counter tick enable |
| irq_en | input | 1 | Wake-up interrupt enable |
| stby | input | 1 | Converter standby indication |
| wake_irq | output | 1 | Wake-up interrupt request |
| xfer_done | output | 1 | Transfer completed (CPL) |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, which give a 16-bit interval, and a two-tick transfer latency. It drives all three tick enables itself, so intervals of two or three ticks expire within a few dozen cycles. A reload value of 0100H lets it show, within the same run, that a LOAD = 0 transfer keeps the old count. Because the bench holds slow ticks off on purpose, the transfer can be kept in flight for as long as needed, and that makes the rule that SET edges are ignored while a transfer is in flight reachable.

// File: rtl/wit_pkg.sv
package wit_pkg;
    localparam logic [7:0] ADDR_CTRL = 8'h94;
    localparam logic [7:0] ADDR_LO   = 8'h95;
    localparam logic [7:0] ADDR_HI   = 8'h96;

    localparam int B_RUN  = 7;
    localparam int B_WUP  = 6;
    localparam int B_TEST = 5;
    localparam int B_CPL  = 4;
    localparam int B_Z1   = 3;
    localparam int B_Z0   = 2;
    localparam int B_LOAD = 1;
    localparam int B_SET  = 0;
endpackage

// File: rtl/wit_sfr_bank.sv
module wit_sfr_bank
    import wit_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              we,
    input  logic              aon_wup,
    input  logic [1:0]        aon_z,
    input  logic              cpl,
    output logic [7:0]        rdata,
    output logic              cfg_run,
    output logic              cfg_wup,
    output logic              cfg_test,
    output logic              cfg_load,
    output logic [1:0]        cfg_z,
    output logic [CNT_W-1:0]  cfg_interval,
    output logic              set_rise,
    output logic              cpl_clr
);
    typedef struct packed {
        logic              run;
        logic              wup;
        logic              test;
        logic              load;
        logic              set;
        logic [1:0]        z;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              setp;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        bank_d.setp = bank_q.set;
        if (we) begin
            case (addr)
                ADDR_CTRL: begin
                    bank_d.run  = wdata[B_RUN];
                    bank_d.wup  = wdata[B_WUP];
                    bank_d.test = wdata[B_TEST];
                    bank_d.z    = wdata[B_Z1:B_Z0];
                    bank_d.load = wdata[B_LOAD];
                    bank_d.set  = wdata[B_SET];
                end
                ADDR_LO: bank_d.lo = wdata[BYTE_W-1:0];
                ADDR_HI: bank_d.hi = wdata[BYTE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {bank_q.run, aon_wup, bank_q.test, cpl,
                                aon_z, bank_q.load, bank_q.set};
            ADDR_LO:   rdata = 8'(bank_q.lo);
            ADDR_HI:   rdata = 8'(bank_q.hi);
            default:   rdata = 8'h00;
        endcase
    end

    assign cfg_run      = bank_q.run;
    assign cfg_wup      = bank_q.wup;
    assign cfg_test     = bank_q.test;
    assign cfg_load     = bank_q.load;
    assign cfg_z        = bank_q.z;
    assign cfg_interval = {bank_q.hi, bank_q.lo};
    assign set_rise     = bank_q.set && !bank_q.setp;
    assign cpl_clr      = we && (addr == ADDR_CTRL) && !wdata[B_CPL];

    // R3: a written 0->1 on SET is seen as a rising edge one cycle later
    assert_set_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_CTRL && wdata[B_SET] && !bank_q.set) |=> set_rise);
endmodule

// File: rtl/wit_xfer.sv
module wit_xfer #(
    parameter int CNT_W     = 16,
    parameter int XFER_SLOW = 2,
    localparam int XC_W     = $clog2(XFER_SLOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_rise,
    input  logic             slow_tick,
    input  logic             cpl_clr,
    input  logic             in_run,
    input  logic             in_wup,
    input  logic             in_load,
    input  logic [1:0]       in_z,
    input  logic [CNT_W-1:0] in_interval,
    output logic             apply,
    output logic             s_run,
    output logic             s_wup,
    output logic             s_load,
    output logic [1:0]       s_z,
    output logic [CNT_W-1:0] s_interval,
    output logic             cpl
);
    localparam logic [XC_W-1:0] LAST = XC_W'(XFER_SLOW - 1);

    typedef struct packed {
        logic             busy;
        logic [XC_W-1:0]  xc;
        logic             cpl;
        logic             run;
        logic             wup;
        logic             load;
        logic [1:0]       z;
        logic [CNT_W-1:0] ival;
    } xfer_t;

    xfer_t xf_d, xf_q;
    logic  apply_c;

    assign apply_c = xf_q.busy && slow_tick && (xf_q.xc == LAST);

    always_comb begin
        xf_d = xf_q;
        if (apply_c) begin
            xf_d.busy = 1'b0;
            xf_d.cpl  = 1'b1;
        end else if (xf_q.busy && slow_tick) begin
            xf_d.xc = xf_q.xc + 1'b1;
        end else if (!xf_q.busy && set_rise) begin
            xf_d.busy = 1'b1;
            xf_d.xc   = '0;
            xf_d.run  = in_run;
            xf_d.wup  = in_wup;
            xf_d.load = in_load;
            xf_d.z    = in_z;
            xf_d.ival = in_interval;
        end
        if (cpl_clr && !apply_c) xf_d.cpl = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xf_q <= '0;
        else        xf_q <= xf_d;
    end

    assign apply      = apply_c;
    assign s_run      = xf_q.run;
    assign s_wup      = xf_q.wup;
    assign s_load     = xf_q.load;
    assign s_z        = xf_q.z;
    assign s_interval = xf_q.ival;
    assign cpl        = xf_q.cpl;

    // R4: an edge during a transfer leaves the captured settings alone
    assert_ignore_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xf_q.busy && set_rise && !apply_c) |=>
        ($stable(s_interval) && $stable(s_z) && $stable(s_run) && $stable(s_load)));
    // R3: completion follows the landing edge
    assert_done_after_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        apply_c |=> cpl);
    // R5: the completion flag holds unless software clears it
    assert_cpl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl && !cpl_clr) |=> cpl);
endmodule

// File: rtl/wit_aon.sv
module wit_aon #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic             s_run,
    input  logic             s_wup,
    input  logic             s_load,
    input  logic [1:0]       s_z,
    input  logic [CNT_W-1:0] s_interval,
    input  logic             test_sel,
    input  logic             norm_tick,
    input  logic             test_tick,
    output logic             wup,
    output logic [1:0]       z
);
    typedef struct packed {
        logic             run;
        logic             wup;
        logic [1:0]       z;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
    } aon_t;

    aon_t ao_d, ao_q;
    logic tick;

    assign tick = test_sel ? test_tick : norm_tick;

    always_comb begin
        ao_d = ao_q;
        if (apply) begin
            ao_d.run    = s_run;
            ao_d.wup    = s_wup;
            ao_d.z      = s_z;
            ao_d.reload = s_interval;
            if (s_load) ao_d.cnt = s_interval;
        end else if (ao_q.run && tick) begin
            if (ao_q.cnt <= CNT_W'(1)) begin
                ao_d.wup = 1'b1;
                ao_d.cnt = ao_q.reload;
            end else begin
                ao_d.cnt = ao_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ao_q <= '0;
        else        ao_q <= ao_d;
    end

    assign wup = ao_q.wup;
    assign z   = ao_q.z;

    // R11: retained bits move only with a transfer
    assert_z_retained_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(z));
    // R7: expiry latches the flag
    assert_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && ao_q.run && tick && ao_q.cnt <= CNT_W'(1)) |=> wup);
    // R7: stopped counter holds
    assert_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && !ao_q.run) |=> $stable(ao_q.cnt));
endmodule

// File: rtl/wake_interval_timer.sv
module wake_interval_timer #(
    parameter int BYTE_W    = 8,
    parameter int XFER_SLOW = 2,
    localparam int CNT_W    = 2 * BYTE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    input  logic       sfr_we,
    output logic [7:0] sfr_rdata,
    input  logic       slow_tick,
    input  logic       norm_tick,
    input  logic       test_tick,
    input  logic       irq_en,
    input  logic       stby,
    output logic       wake_irq,
    output logic       xfer_done
);
    logic             cfg_run, cfg_wup, cfg_test, cfg_load;
    logic [1:0]       cfg_z;
    logic [CNT_W-1:0] cfg_interval;
    logic             set_rise, cpl_clr, cpl;
    logic             apply, s_run, s_wup, s_load;
    logic [1:0]       s_z;
    logic [CNT_W-1:0] s_interval;
    logic             aon_wup;
    logic [1:0]       aon_z;

    wit_sfr_bank #(.BYTE_W(BYTE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wdata(sfr_wdata), .we(sfr_we),
        .aon_wup(aon_wup), .aon_z(aon_z), .cpl(cpl), .rdata(sfr_rdata),
        .cfg_run(cfg_run), .cfg_wup(cfg_wup), .cfg_test(cfg_test), .cfg_load(cfg_load),
        .cfg_z(cfg_z), .cfg_interval(cfg_interval), .set_rise(set_rise), .cpl_clr(cpl_clr)
    );

    wit_xfer #(.CNT_W(CNT_W), .XFER_SLOW(XFER_SLOW)) u_xfer (
        .clk(clk), .rst_n(rst_n), .set_rise(set_rise), .slow_tick(slow_tick),
        .cpl_clr(cpl_clr), .in_run(cfg_run), .in_wup(cfg_wup), .in_load(cfg_load),
        .in_z(cfg_z), .in_interval(cfg_interval), .apply(apply), .s_run(s_run),
        .s_wup(s_wup), .s_load(s_load), .s_z(s_z), .s_interval(s_interval), .cpl(cpl)
    );

    wit_aon #(.CNT_W(CNT_W)) u_aon (
        .clk(clk), .rst_n(rst_n), .apply(apply), .s_run(s_run), .s_wup(s_wup),
        .s_load(s_load), .s_z(s_z), .s_interval(s_interval), .test_sel(cfg_test),
        .norm_tick(norm_tick), .test_tick(test_tick), .wup(aon_wup), .z(aon_z)
    );

    assign wake_irq  = irq_en && (cpl || (aon_wup && stby));
    assign xfer_done = cpl;

    // R10: no request without the enable
    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !wake_irq);
endmodule

// File: tb/wake_interval_timer_tb.sv
module wake_interval_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_rdata;
    logic       slow_tick = 1'b0, norm_tick = 1'b0, test_tick = 1'b0;
    logic       irq_en = 1'b0, stby = 1'b0;
    logic       wake_irq, xfer_done;
    logic       slow_en = 1'b1, norm_en = 1'b1;
    int         ph = 0;
    int         checks = 0, errors = 0;
    bit         finished = 1'b0;

    wake_interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .slow_tick(slow_tick),
        .norm_tick(norm_tick), .test_tick(test_tick), .irq_en(irq_en), .stby(stby),
        .wake_irq(wake_irq), .xfer_done(xfer_done)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        ph        <= ph + 1;
        slow_tick <= slow_en && (ph % 4 == 0);
        norm_tick <= norm_en && (ph % 3 == 0);
        test_tick <= (ph % 2 == 1);
    end

    // reference model
    logic m_run, m_wup, m_test, m_load, m_set, m_setp, m_cpl, m_busy;
    logic [1:0] m_z, s_z, a_z;
    logic [7:0] m_lo, m_hi;
    int   m_xc;
    logic s_run, s_wup, s_load, a_run, a_wup;
    logic [15:0] s_int, a_rel, a_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_run, m_wup, m_test, m_load, m_set, m_setp, m_cpl, m_busy} = '0;
            m_z = 0; s_z = 0; a_z = 0; m_lo = 0; m_hi = 0; m_xc = 0;
            {s_run, s_wup, s_load, a_run, a_wup} = '0;
            s_int = 0; a_rel = 0; a_cnt = 0;
        end else begin
            bit ap, tk, rise;
            ap   = m_busy && slow_tick && m_xc == 1;
            tk   = m_test ? test_tick : norm_tick;
            rise = m_set && !m_setp;
            if (ap) begin
                a_run = s_run; a_wup = s_wup; a_z = s_z; a_rel = s_int;
                if (s_load) a_cnt = s_int;
            end else if (a_run && tk) begin
                if (a_cnt <= 1) begin a_wup = 1; a_cnt = a_rel; end
                else a_cnt = a_cnt - 1;
            end
            if (ap) begin m_busy = 0; m_cpl = 1; end
            else if (m_busy && slow_tick) m_xc = m_xc + 1;
            else if (!m_busy && rise) begin
                m_busy = 1; m_xc = 0; s_run = m_run; s_wup = m_wup;
                s_load = m_load; s_z = m_z; s_int = {m_hi, m_lo};
            end
            if (sfr_we && sfr_addr == 8'h94 && !sfr_wdata[4] && !ap) m_cpl = 0;
            m_setp = m_set;
            if (sfr_we) begin
                if (sfr_addr == 8'h94) begin
                    m_run = sfr_wdata[7]; m_wup = sfr_wdata[6]; m_test = sfr_wdata[5];
                    m_z = sfr_wdata[3:2]; m_load = sfr_wdata[1]; m_set = sfr_wdata[0];
                end else if (sfr_addr == 8'h95) m_lo = sfr_wdata;
                else if (sfr_addr == 8'h96) m_hi = sfr_wdata;
            end
        end
    end

    function automatic logic [7:0] m_rd(input logic [7:0] a);
        case (a)
            8'h94:   return {m_run, a_wup, m_test, m_cpl, a_z, m_load, m_set};
            8'h95:   return m_lo;
            8'h96:   return m_hi;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            chk("R10 wake_irq", {7'd0, wake_irq}, {7'd0, irq_en && (m_cpl || (a_wup && stby))});
            chk("R5 xfer_done", {7'd0, xfer_done}, {7'd0, m_cpl});
            chk("R1 rdata", sfr_rdata, m_rd(sfr_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(negedge clk); sfr_we = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a,
                         input logic [7:0] mask, input logic [7:0] exp);
        sfr_addr = a; #1;
        chk(tag, sfr_rdata & mask, exp);
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1'b1; checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        waitc(4); rst_n = 1'b1; waitc(1);
        rdchk("R2 ctrl", 8'h94, 8'hFF, 8'h00);
        rdchk("R2 lo", 8'h95, 8'hFF, 8'h00);
        rdchk("R2 hi", 8'h96, 8'hFF, 8'h00);
        rdchk("R1 unmapped", 8'h50, 8'hFF, 8'h00);
        rdchk("R1 unmapped", 8'h97, 8'hFF, 8'h00);
        // transfer with interval 3, RUN and LOAD
        wr(8'h95, 8'h03); wr(8'h96, 8'h00);
        rdchk("R1 lo", 8'h95, 8'hFF, 8'h03);
        slow_en = 1'b0;
        wr(8'h94, 8'h82); wr(8'h94, 8'h83);
        waitc(4);
        chk("R3 held without slow ticks", {7'd0, xfer_done}, 8'h00);
        wr(8'h94, 8'h8E); wr(8'h94, 8'h8F);   // R4 edge during transfer
        slow_en = 1'b1;
        waitc(12);
        chk("R3 done after transfer", {7'd0, xfer_done}, 8'h01);
        rdchk("R4 z kept from first capture", 8'h94, 8'h0C, 8'h00);
        // R5 completion clear rules
        wr(8'h94, 8'h93); waitc(2);
        chk("R5 write 1 keeps", {7'd0, xfer_done}, 8'h01);
        wr(8'h94, 8'h83); waitc(1);
        chk("R5 write 0 clears", {7'd0, xfer_done}, 8'h00);
        // R7 expiry
        irq_en = 1'b1; stby = 1'b1;
        waitc(15);
        rdchk("R7 flag after expiry", 8'h94, 8'h40, 8'h40);
        chk("R10 irq with stby", {7'd0, wake_irq}, 8'h01);
        stby = 1'b0; waitc(1);
        chk("R10 irq masked by stby", {7'd0, wake_irq}, 8'h00);
        stby = 1'b1;
        // R8 clear through transfer
        wr(8'h94, 8'h02);
        rdchk("R8 read is always-on copy", 8'h94, 8'h40, 8'h40);
        wr(8'h94, 8'h03); waitc(12);
        rdchk("R8 cleared by transfer", 8'h94, 8'h40, 8'h00);
        waitc(10);
        rdchk("R7 stopped stays clear", 8'h94, 8'h40, 8'h00);
        wr(8'h94, 8'h02);
        wr(8'h94, 8'h40); wr(8'h94, 8'h41); waitc(12);
        rdchk("R8 software set", 8'h94, 8'h40, 8'h40);
        wr(8'h94, 8'h00); wr(8'h94, 8'h01); waitc(12); wr(8'h94, 8'h00);
        // R6 LOAD=0 keeps count
        wr(8'h95, 8'h00); wr(8'h96, 8'h01);
        wr(8'h94, 8'h02); wr(8'h94, 8'h03); waitc(12);
        wr(8'h95, 8'h02); wr(8'h96, 8'h00);
        wr(8'h94, 8'h80); wr(8'h94, 8'h81); waitc(40);
        rdchk("R6 no reload without LOAD", 8'h94, 8'h40, 8'h00);
        // R9 test clock select
        wr(8'h94, 8'h02); wr(8'h94, 8'h03); waitc(12);
        norm_en = 1'b0;
        wr(8'h94, 8'h80); wr(8'h94, 8'h81); waitc(20);
        rdchk("R9 no normal ticks", 8'h94, 8'h40, 8'h00);
        wr(8'h94, 8'hA0); wr(8'h94, 8'hA1); waitc(20);
        rdchk("R9 test ticks count", 8'h94, 8'h40, 8'h40);
        norm_en = 1'b1;
        // R11 retained bits
        wr(8'h94, 8'h0C); wr(8'h94, 8'h0D); waitc(12);
        rdchk("R11 z after transfer", 8'h94, 8'h0C, 8'h0C);
        wr(8'h94, 8'h00);
        rdchk("R11 z unchanged by write", 8'h94, 8'h0C, 8'h0C);
        waitc(4);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule